// File: doc/BRIEF.md
# Non-restoring sequential unsigned divider

This block divides an unsigned 32-bit dividend by a 32-bit divisor over several clock cycles, one add-or-subtract step per clock. The caller picks the quotient width with a step count between 1 and 32. The upper dividend bits form the first partial remainder. The lower bits are pulled in one per step as quotient bits are produced. Each step either subtracts or adds the divisor back, depending on the previous quotient bit, so no restore cycle is ever needed.

A request is made by pulsing `start_i` while the block is idle. `busy_o` is high while the steps run. `done_o` pulses for one cycle when the quotient, the corrected remainder and an overflow flag are ready. The overflow flag merges two conditions. The first is a divide-by-zero detector: it is seeded by a zero divisor and is also set when the running sign flips without a carry. The second is an all-ones detector: it stays set only while every quotient bit is 1 and no step sum is zero. A set flag marks the quotient as out of range for the chosen width.

Top module: `nrdiv_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `overflow_o`, `quotient_o` and `remainder_o` are all zero.
- R2: A `start_i` sampled high while idle sets `busy_o` at that edge. Exactly N further edges each perform one step. The last of them clears `busy_o` and raises `done_o` for exactly one cycle.
- R3: When `overflow_o` is 0, `quotient_o` equals dividend / divisor and `remainder_o` equals dividend mod divisor, which is below the divisor.
- R4: The step count N (1 to 32) sets the quotient width. The first partial remainder is the dividend shifted right by N-1, and quotient bits at position N and above are zero.
- R5: A zero divisor always gives `overflow_o` = 1.
- R6: When every one of the N quotient bits is 1 and no step sum is zero, `overflow_o` is 1. For example, 8 / 1 with N = 2 gives quotient 3, remainder 5 and overflow 1.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The running division completes on its original schedule with its original operands.
- R8: The three result ports keep their values from `done_o` until the next accepted `start_i`.
- R9: When the last quotient bit is 0, the remainder is the final step sum plus the divisor. For example, 100 / 7 gives quotient 14 and remainder 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division (accepted only when idle) |
| dividend_i | input | 32 | Dividend operand |
| divisor_i | input | 32 | Divisor operand |
| steps_i | input | 6 | Step count N, valid range 1 to 32 |
| busy_o | output | 1 | Steps in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| quotient_o | output | 32 | Quotient, N bits wide |
| remainder_o | output | 32 | Corrected remainder |
| overflow_o | output | 1 | Divide-by-zero or out-of-range quotient |

## Verification
On every cycle, the assertions check these rules: the done pulse is a single cycle that follows a busy period, operands are frozen against a start while busy, and results hold while idle. At every completion they also check that a zero divisor yields overflow, that quotient bits above N are clear, and that an unflagged remainder is below the divisor. The exact quotient and remainder values, the step count from start to done, and the overflow outcome for an all-ones quotient can only be shown by the bench's operand scenarios. These include several step counts, N = 1, and a start injected in the middle of a division.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = $clog2(DATA_W) + 1;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  nsteps;
        logic [DATA_W-1:0] part;
        logic [DATA_W-1:0] bits;
        logic [DATA_W-1:0] dvs;
        logic              qb;
        logic              sg;
        logic              dbz;
        logic              aux;
        logic [DATA_W-1:0] quo;
        logic [DATA_W-1:0] rem;
        logic              ovf;
    } nrdiv_st_t;
endpackage

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] part_i,
    input  logic [W-1:0] dvs_i,
    input  logic         qprev_i,
    input  logic         sprev_i,
    output logic [W-1:0] sum_o,
    output logic         qbit_o,
    output logic         dbz_hit_o,
    output logic         zero_o
);
    logic [W-1:0] addend;
    logic         carry_raw;
    logic         carry;

    always_comb begin
        addend    = qprev_i ? ~dvs_i : dvs_i;
        sum_o     = part_i + addend + {{(W-1){1'b0}}, qprev_i};
        carry_raw = (addend[W-1] & part_i[W-1]) |
                    ((addend[W-1] ^ part_i[W-1]) & ~sum_o[W-1]);
        carry     = carry_raw ^ qprev_i;
        qbit_o    = ~(carry ^ sprev_i);
        dbz_hit_o = (sprev_i ^ sum_o[W-1]) & ~carry;
        zero_o    = (sum_o == '0);
    end
endmodule

// File: rtl/nrdiv_fix.sv
module nrdiv_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] sum_i,
    input  logic [W-1:0] dvs_i,
    input  logic         qlast_i,
    output logic [W-1:0] rem_o
);
    always_comb begin
        rem_o = qlast_i ? sum_i : (sum_i + dvs_i);
    end
endmodule

// File: rtl/nrdiv_seq.sv
module nrdiv_seq
    import nrdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] dividend_i,
    input  logic [DATA_W-1:0] divisor_i,
    input  logic [CNT_W-1:0]  steps_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] quotient_o,
    output logic [DATA_W-1:0] remainder_o,
    output logic              overflow_o
);
    localparam int WIDE_W = 2 * DATA_W;

    nrdiv_st_t st_q, st_d;

    logic [DATA_W-1:0] step_sum;
    logic              step_q;
    logic              step_dbz;
    logic              step_zero;
    logic [DATA_W-1:0] fix_rem;
    logic [CNT_W:0]    low_shift_d;
    logic [WIDE_W-1:0] low_wide_d;

    nrdiv_step #(.W(DATA_W)) u_step (
        .part_i    (st_q.part),
        .dvs_i     (st_q.dvs),
        .qprev_i   (st_q.qb),
        .sprev_i   (st_q.sg),
        .sum_o     (step_sum),
        .qbit_o    (step_q),
        .dbz_hit_o (step_dbz),
        .zero_o    (step_zero)
    );

    nrdiv_fix #(.W(DATA_W)) u_fix (
        .sum_i   (step_sum),
        .dvs_i   (st_q.dvs),
        .qlast_i (step_q),
        .rem_o   (fix_rem)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        low_shift_d = (CNT_W+1)'(DATA_W + 1) - {1'b0, steps_i};
        low_wide_d  = {{DATA_W{1'b0}}, dividend_i} << low_shift_d;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy   = 1'b1;
                st_d.cnt    = steps_i;
                st_d.nsteps = steps_i;
                st_d.part   = dividend_i >> (steps_i - 1'b1);
                st_d.bits   = low_wide_d[DATA_W-1:0];
                st_d.dvs    = divisor_i;
                st_d.qb     = 1'b1;
                st_d.sg     = 1'b0;
                st_d.dbz    = (divisor_i == '0);
                st_d.aux    = 1'b1;
            end
        end else begin
            st_d.part = {step_sum[DATA_W-2:0], st_q.bits[DATA_W-1]};
            st_d.bits = {st_q.bits[DATA_W-2:0], step_q};
            st_d.qb   = step_q;
            st_d.sg   = step_sum[DATA_W-1];
            st_d.dbz  = st_q.dbz | step_dbz;
            st_d.aux  = step_zero ? 1'b0 : (st_q.aux & step_q);
            st_d.cnt  = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.quo  = {st_q.bits[DATA_W-2:0], step_q};
                st_d.rem  = fix_rem;
                st_d.ovf  = st_d.dbz | st_d.aux;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = st_q.busy;
    assign done_o      = st_q.done;
    assign quotient_o  = st_q.quo;
    assign remainder_o = st_q.rem;
    assign overflow_o  = st_q.ovf;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !busy_o && $past(busy_o)); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> $stable(st_q.dvs) && $stable(st_q.nsteps)); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !start_i |=> $stable(quotient_o) && $stable(remainder_o) && $stable(overflow_o)); // R8
    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && (st_q.dvs == '0) |-> overflow_o); // R5
    AST_QUOTIENT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && (st_q.nsteps < CNT_W'(DATA_W)) |-> ((quotient_o >> st_q.nsteps) == '0)); // R4
    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !overflow_o |-> remainder_o < st_q.dvs); // R3
endmodule

// File: tb/sim_nrdiv_seq.sv
module sim_nrdiv_seq;
    typedef struct packed {
        logic [5:0]  n;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] q;
        logic [31:0] r;
        logic        ov;
        logic        chk_qr;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{6'd32, 32'd100,        32'd7,          32'd14,         32'd2,   1'b0, 1'b1},
        '{6'd32, 32'hFFFF_FFFF,  32'h10,         32'h0FFF_FFFF,  32'hF,   1'b0, 1'b1},
        '{6'd32, 32'd12345678,   32'd1000,       32'd12345,      32'd678, 1'b0, 1'b1},
        '{6'd32, 32'd5,          32'd9,          32'd0,          32'd5,   1'b0, 1'b1},
        '{6'd32, 32'd0,          32'd3,          32'd0,          32'd0,   1'b0, 1'b1},
        '{6'd8,  32'd200,        32'd3,          32'd66,         32'd2,   1'b0, 1'b1},
        '{6'd16, 32'h12345,      32'h10,         32'h1234,       32'd5,   1'b0, 1'b1},
        '{6'd32, 32'h7FFF_FFFF,  32'h7FFF_FFFF,  32'd1,          32'd0,   1'b0, 1'b1},
        '{6'd1,  32'd1,          32'd1,          32'd1,          32'd0,   1'b0, 1'b1},
        '{6'd2,  32'd8,          32'd1,          32'd3,          32'd5,   1'b1, 1'b1},
        '{6'd32, 32'd77,         32'd0,          32'd0,          32'd0,   1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] dvd = '0;
    logic [31:0] dvs = '0;
    logic [5:0]  nst = '0;
    logic        busy, done, ovf;
    logic [31:0] quo, rem;
    int          checks = 0;
    int          fails = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    nrdiv_seq u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .dividend_i  (dvd),
        .divisor_i   (dvs),
        .steps_i     (nst),
        .busy_o      (busy),
        .done_o      (done),
        .quotient_o  (quo),
        .remainder_o (rem),
        .overflow_o  (ovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Runs one division; inj > 0 pulses start with other operands at that negedge.
    task automatic run(input logic [5:0] n, input logic [31:0] a, input logic [31:0] b,
                       input int inj, output int k);
        @(negedge clk);
        dvd = a; dvs = b; nst = n; start = 1'b1;
        k = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            k++;
            start = 1'b0;
            if (k == 1) chk("R2 busy after start", 32'(busy), 32'd1);
            if (inj > 0 && k == inj) begin
                dvd = 32'd999; dvs = 32'd5; nst = 6'd3; start = 1'b1;
            end
            if (done) break;
        end
    endtask

    initial begin
        int k;
        logic [31:0] hq, hr;
        logic        ho;
        repeat (3) @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 quotient", quo, 32'd0);
        chk("R1 remainder", rem, 32'd0);
        chk("R1 overflow", 32'(ovf), 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            run(VEC[v].n, VEC[v].a, VEC[v].b, 0, k);
            chk("R2 cycles to done", 32'(k), 32'(VEC[v].n) + 32'd1);
            chk("R2 busy cleared", 32'(busy), 32'd0);
            chk(VEC[v].ov ? "R5/R6 overflow set" : "R3 overflow clear", 32'(ovf), 32'(VEC[v].ov));
            if (VEC[v].chk_qr) begin
                chk("R3/R4 quotient", quo, VEC[v].q);
                chk("R3/R9 remainder", rem, VEC[v].r);
            end
        end

        // R7: start injected mid-run is ignored
        run(6'd32, 32'd100, 32'd7, 3, k);
        chk("R7 cycles unchanged", 32'(k), 32'd33);
        chk("R7 quotient", quo, 32'd14);
        chk("R7 remainder", rem, 32'd2);
        @(negedge clk);
        start = 1'b0;
        chk("R7 no second run", 32'(busy), 32'd0);

        // R8: results hold while idle
        hq = quo; hr = rem; ho = ovf;
        dvd = 32'h5555; dvs = 32'd0; nst = 6'd4;
        repeat (6) @(negedge clk);
        chk("R8 quotient held", quo, hq);
        chk("R8 remainder held", rem, hr);
        chk("R8 overflow held", 32'(ovf), 32'(ho));
        chk("R2 done single pulse", 32'(done), 32'd0);

        // R6: all-ones quotient with nonzero sums, N = 3: 7*8=56 / 1 style
        run(6'd3, 32'd100, 32'd1, 0, k);
        chk("R6 overflow on out-of-range", 32'(ovf), 32'd1);
        chk("R4 quotient width", quo >> 3, 32'd0);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule